// File: doc/BRIEF.md
# Tile Row Extract and Convert Unit

This block holds a small matrix tile (up to 16 rows of 64 bytes) and, on request, pulls one 64-byte slice of one row out as a 512-bit vector. A 32-bit selector word carries both the row to read and which 64-byte chunk of that row to take. A 3-bit operation code decides what happens to the slice. It can be passed through byte for byte. It can be read as sixteen signed 32-bit integers and turned into single precision. It can be read as sixteen single-precision values and narrowed to bfloat16 or IEEE half precision, with each narrowed value placed in either the upper or the lower half of its 32-bit lane.

Anything beyond the tile's configured row width in bytes reads as zero. Narrowing always rounds to nearest-even and raises no flags. The result is registered, and a valid strobe follows the request strobe by one cycle. A separate write port loads whole rows into the tile storage.

Top module: `tre_row_unit`

## Requirements
- R1: While reset is held and after it, until the first request, `out_valid` is 0 and `out_vec` is all zeros.
- R2: `out_valid` is 1 in exactly the cycle after a cycle with `req_valid` high. `out_vec` keeps its value through cycles without a request.
- R3: `req_sel[15:0]` selects the row and `req_sel[31:16]` selects the chunk, whose byte offset is chunk × 64. A row index of 16 or above gives an all-zero vector.
- R4: Operation code 0 (move) sets output byte i (bits 8i+7:8i) to row byte (offset + i). The byte is zero when offset + i ≥ `colsb`.
- R5: In operation codes 1 to 5, 32-bit lane i (bits 32i+31:32i) is zero when i + offset/4 ≥ floor(`colsb`/4). Otherwise it is computed from source dword offset/4 + i.
- R6: Operation code 1 converts each signed 32-bit integer to single precision with round-to-nearest-even.
- R7: Operation code 2 writes the round-to-nearest-even bfloat16 of each single-precision lane into lane bits 31:16 and zeroes bits 15:0. Operation code 3 writes it into bits 15:0 and zeroes bits 31:16.
- R8: Operation codes 4 (upper half) and 5 (lower half) do the same with an IEEE half-precision result. Values out of range become an infinity of the same sign, half-precision subnormals are produced, and single-precision denormals are rounded, not flushed.
- R9: A single-precision NaN narrows to a quiet NaN with the input's sign: 0x7FC0 for bfloat16 and 0x7E00 for half precision, with bit 15 set for a negative input.
- R10: Operation codes 6 and 7 return an all-zero vector.
- R11: With `wr_en` high at a clock edge, `wr_data` becomes row `wr_row`, byte k in bits 8k+7:8k. Later reads of that row return the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Row write strobe |
| wr_row | input | 4 | Row written |
| wr_data | input | 512 | Row contents to write |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 32 | Row index [15:0], chunk number [31:16] |
| req_op | input | 3 | Operation code 0..7 |
| colsb | input | 7 | Configured bytes per row; values above 64 act as 64 |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_vec | output | 512 | Registered result vector |

## Verification
The bench goes after rounding ties, where a design that rounds half-up instead of to even is off by one unit in the last place. It also covers the half-precision edge at 65520, which must become infinity, and half-precision subnormal outputs, which a design that flushes them would return as zero. With `colsb` set to 6, move mode keeps six bytes while the conversion modes keep only one lane, so a design that applies the byte rule to lanes, or the lane rule to bytes, shows up at once. Further cases are a nonzero chunk, an out-of-range row, unused operation codes and signed NaN inputs. Each of these would leak stale row data or a wrongly signed or signalling NaN if the design got it wrong.

// File: rtl/tre_pkg.sv
// Shared operation codes and per-lane numeric conversions for the tile row unit.
// Assumes IEEE single precision inputs; all rounding is to nearest, ties to even.
package tre_pkg;

    typedef enum logic [2:0] {
        OP_MOVE  = 3'd0,
        OP_I2F   = 3'd1,
        OP_BF16H = 3'd2,
        OP_BF16L = 3'd3,
        OP_F16H  = 3'd4,
        OP_F16L  = 3'd5
    } op_t;

    // Signed 32-bit integer to single precision, ties to even.
    function automatic logic [31:0] i32_to_f32(input logic [31:0] x);
        logic        s;
        logic [31:0] mag;
        logic [31:0] norm;
        logic [30:0] base;
        logic        rnd;
        int          msb;
        s   = x[31];
        mag = s ? (~x + 32'd1) : x;
        if (mag == 32'd0) return 32'd0;
        msb = 0;
        for (int k = 0; k < 32; k++) if (mag[k]) msb = k;
        norm = mag << (31 - msb);
        rnd  = norm[7] & ((|norm[6:0]) | norm[8]);
        base = {8'(127 + msb), norm[30:8]};
        return {s, base + 31'(rnd)};
    endfunction

    // Single precision to bfloat16, ties to even, NaN made quiet.
    function automatic logic [15:0] f32_to_bf16(input logic [31:0] f);
        logic rnd;
        if (f[30:23] == 8'hFF && f[22:0] != 23'd0) return {f[31], 15'h7FC0};
        rnd = f[15] & ((|f[14:0]) | f[16]);
        return {f[31], f[30:16] + 15'(rnd)};
    endfunction

    // Single precision to IEEE half, ties to even, with overflow and subnormals.
    function automatic logic [15:0] f32_to_f16(input logic [31:0] f);
        logic        s;
        logic [7:0]  e;
        logic [22:0] m;
        logic [23:0] sig;
        logic [49:0] wide;
        logic [4:0]  he;
        logic        rnd;
        int          sh;
        s = f[31];
        e = f[30:23];
        m = f[22:0];
        if (e == 8'hFF) return (m != 23'd0) ? {s, 15'h7E00} : {s, 15'h7C00};
        if (e >= 8'd143) return {s, 15'h7C00};
        if (e >= 8'd113) begin
            he  = 5'(e - 8'd112);
            rnd = m[12] & ((|m[11:0]) | m[13]);
            return {s, {he, m[22:13]} + 15'(rnd)};
        end
        sh = 126 - ((e == 8'd0) ? 1 : int'(e));
        if (sh > 26) sh = 26;
        sig  = {(e != 8'd0), m};
        wide = {sig, 26'd0} >> sh;
        rnd  = wide[25] & ((|wide[24:0]) | wide[26]);
        return {s, 15'(wide[49:26]) + 15'(rnd)};
    endfunction

endpackage

// File: rtl/tre_tile_store.sv
// Tile storage: ROWS rows of ROW_BITS each, one synchronous write port and
// one combinational read port. Assumes the caller range-checks the read index.
module tre_tile_store #(
    parameter int ROWS     = 16,
    parameter int ROW_BITS = 512,
    parameter int IDX_W    = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_row,
    input  logic [ROW_BITS-1:0] wr_data,
    input  logic [IDX_W-1:0]    rd_row,
    output logic [ROW_BITS-1:0] rd_data
);
    logic [ROW_BITS-1:0] rows_q [ROWS];

    // Load one whole row per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) rows_q[wr_row] <= wr_data;
    end

    // Present the addressed row.
    always_comb rd_data = rows_q[rd_row];

endmodule

// File: rtl/tre_lane_conv.sv
// One 32-bit lane of the conversion path: applies the selected conversion to
// a source dword and places the narrowed value in the upper or lower half.
// Assumes 'on' already folds in the row-width limit for this lane.
module tre_lane_conv
    import tre_pkg::*;
(
    input  op_t         op,
    input  logic [31:0] src,
    input  logic        on,
    output logic [31:0] res
);
    logic [15:0] bf;
    logic [15:0] hf;

    // Narrowed candidates for this lane.
    always_comb begin
        bf = f32_to_bf16(src);
        hf = f32_to_f16(src);
    end

    // Pick the lane result by operation, zero when the lane is past the row width.
    always_comb begin
        res = 32'd0;
        if (on) begin
            case (op)
                OP_I2F:   res = i32_to_f32(src);
                OP_BF16H: res = {bf, 16'd0};
                OP_BF16L: res = {16'd0, bf};
                OP_F16H:  res = {hf, 16'd0};
                OP_F16L:  res = {16'd0, hf};
                default:  res = 32'd0;
            endcase
        end
    end

endmodule

// File: rtl/tre_row_unit.sv
// Tile row extract and convert unit. A request selects a row and a 64-byte
// chunk, masks bytes or lanes past colsb, applies the operation and registers
// the vector with a valid strobe one cycle later. Assumes ROW_BYTES equals the
// output vector width in bytes and is a multiple of 4.
module tre_row_unit
    import tre_pkg::*;
#(
    parameter int ROWS      = 16,
    parameter int ROW_BYTES = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(ROWS)-1:0]         wr_row,
    input  logic [ROW_BYTES*8-1:0]          wr_data,
    input  logic                            req_valid,
    input  logic [31:0]                     req_sel,
    input  logic [2:0]                      req_op,
    input  logic [$clog2(ROW_BYTES):0]      colsb,
    output logic                            out_valid,
    output logic [ROW_BYTES*8-1:0]          out_vec
);
    localparam int VEC_W  = ROW_BYTES * 8;
    localparam int LANES  = ROW_BYTES / 4;
    localparam int IDX_W  = $clog2(ROWS);
    localparam int OFF_SH = $clog2(ROW_BYTES);
    localparam logic [VEC_W-1:0] LO_MASK = {LANES{32'h0000FFFF}};
    localparam logic [VEC_W-1:0] HI_MASK = {LANES{32'hFFFF0000}};

    op_t              op;
    logic [15:0]      sel_row;
    logic [15:0]      sel_chunk;
    logic             row_ok;
    logic [31:0]      chunk_off;
    logic [31:0]      lim;
    logic [VEC_W-1:0] row_data;
    logic [VEC_W-1:0] raw_vec;
    logic [VEC_W-1:0] conv_vec;
    logic [VEC_W-1:0] nxt_vec;

    // Decode the selector, opcode and effective row width.
    always_comb begin
        op        = op_t'(req_op);
        sel_row   = req_sel[15:0];
        sel_chunk = req_sel[31:16];
        row_ok    = (sel_row < 16'(ROWS));
        chunk_off = {16'd0, sel_chunk} << OFF_SH;
        lim       = (int'(colsb) > ROW_BYTES) ? 32'(ROW_BYTES) : 32'(colsb);
    end

    tre_tile_store #(
        .ROWS     (ROWS),
        .ROW_BITS (VEC_W),
        .IDX_W    (IDX_W)
    ) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_row  (sel_row[IDX_W-1:0]),
        .rd_data (row_data)
    );

    // Byte path for the move operation: keep bytes inside the row width.
    for (genvar gb = 0; gb < ROW_BYTES; gb++) begin : g_byte
        assign raw_vec[gb*8 +: 8] =
            ((chunk_off + 32'(gb)) < lim) ? row_data[gb*8 +: 8] : 8'd0;
    end

    // Lane path for the conversions: lane cut-off uses whole dwords.
    for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
        logic lane_on;
        assign lane_on = ((chunk_off >> 2) + 32'(gl)) < (lim >> 2);
        tre_lane_conv u_conv (
            .op  (op),
            .src (row_data[gl*32 +: 32]),
            .on  (lane_on),
            .res (conv_vec[gl*32 +: 32])
        );
    end

    // Select the result by opcode; bad rows and unused codes give zero.
    always_comb begin
        nxt_vec = '0;
        if (row_ok) begin
            case (op)
                OP_MOVE:                                   nxt_vec = raw_vec;
                OP_I2F, OP_BF16H, OP_BF16L, OP_F16H, OP_F16L: nxt_vec = conv_vec;
                default:                                   nxt_vec = '0;
            endcase
        end
    end

    // Register the result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) out_vec <= nxt_vec;
        end
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(out_vec));

    a_r3_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_sel[15:0] >= 16'(ROWS)) |=> out_vec == '0);

    a_r7_bf16_high_clears_low: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd2 |=> (out_vec & LO_MASK) == '0);

    a_r7_bf16_low_clears_high: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd3 |=> (out_vec & HI_MASK) == '0);

    a_r8_f16_placement: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd5 |=> (out_vec & HI_MASK) == '0);

    a_r10_unused_op: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op[2:1] == 2'b11 |=> out_vec == '0);

endmodule

// File: tb/sim_tre_row_unit.sv
module sim_tre_row_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [3:0]   wr_row;
    logic [511:0] wr_data;
    logic         req_valid;
    logic [31:0]  req_sel;
    logic [2:0]   req_op;
    logic [6:0]   colsb;
    logic         out_valid;
    logic [511:0] out_vec;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    tre_row_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
        .wr_data(wr_data), .req_valid(req_valid), .req_sel(req_sel),
        .req_op(req_op), .colsb(colsb), .out_valid(out_valid), .out_vec(out_vec)
    );

    // {op, source dword, expected lane}
    localparam int NV = 28;
    localparam logic [66:0] VECS [NV] = '{
        {3'd0, 32'hDEADBEEF, 32'hDEADBEEF},
        {3'd1, 32'h00000001, 32'h3F800000},
        {3'd1, 32'hFFFFFFFF, 32'hBF800000},
        {3'd1, 32'h00000000, 32'h00000000},
        {3'd1, 32'h01000001, 32'h4B800000},
        {3'd1, 32'h01000003, 32'h4B800002},
        {3'd1, 32'h80000000, 32'hCF000000},
        {3'd1, 32'h7FFFFFFF, 32'h4F000000},
        {3'd2, 32'h3F800000, 32'h3F800000},
        {3'd2, 32'h3F808000, 32'h3F800000},
        {3'd2, 32'h3F818000, 32'h3F820000},
        {3'd2, 32'hFF800001, 32'hFFC00000},
        {3'd3, 32'h3F818000, 32'h00003F82},
        {3'd3, 32'h7F7FFFFF, 32'h00007F80},
        {3'd4, 32'h3F800000, 32'h3C000000},
        {3'd4, 32'h477FF000, 32'h7C000000},
        {3'd4, 32'hC9742400, 32'hFC000000},
        {3'd5, 32'h33800000, 32'h00000001},
        {3'd5, 32'h33000000, 32'h00000000},
        {3'd5, 32'h33000001, 32'h00000001},
        {3'd5, 32'h00000001, 32'h00000000},
        {3'd5, 32'h7F800001, 32'h00007E00},
        {3'd5, 32'h3F000000, 32'h00003800},
        {3'd5, 32'h3F801000, 32'h00003C00},
        {3'd5, 32'h3F803000, 32'h00003C02},
        {3'd6, 32'h3F800000, 32'h00000000},
        {3'd7, 32'h3F800000, 32'h00000000},
        {3'd4, 32'hFF800000, 32'hFC000000}
    };

    function automatic string req_of(input logic [2:0] op, input logic [31:0] src);
        if (op == 3'd0) return "R4";
        if (op == 3'd1) return "R6";
        if (src[30:23] == 8'hFF && src[22:0] != 0) return "R9";
        if (op == 3'd2 || op == 3'd3) return "R7";
        if (op == 3'd4 || op == 3'd5) return "R8";
        return "R10";
    endfunction

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic write_row(input logic [3:0] r, input logic [511:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_row = r; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Issue a request; on return the registered result is visible.
    task automatic request(input logic [2:0] op, input logic [31:0] sel, input logic [6:0] cb);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sel = sel; colsb = cb;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int cyc = 0; cyc < 200000; cyc++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [511:0] ramp;
        logic [511:0] held;
        logic [511:0] exp;
        rst_n = 1'b0; wr_en = 1'b0; wr_row = '0; wr_data = '0;
        req_valid = 1'b0; req_sel = '0; req_op = '0; colsb = 7'd64;
        repeat (3) @(negedge clk);
        check("R1", {511'd0, out_valid}, '0);
        check("R1", out_vec, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {511'd0, out_valid}, '0);
        check("R1", out_vec, '0);

        // Vector table: every lane of row 0 holds the source dword.
        for (int v = 0; v < NV; v++) begin
            write_row(4'd0, {16{VECS[v][63:32]}});
            request(VECS[v][66:64], 32'h0, 7'd64);
            check(req_of(VECS[v][66:64], VECS[v][63:32]), out_vec, {16{VECS[v][31:0]}});
        end

        // R11: byte k of row 1 is k+1; row 2 holds 1.0 in every lane.
        for (int k = 0; k < 64; k++) ramp[k*8 +: 8] = 8'(k + 1);
        write_row(4'd1, ramp);
        write_row(4'd2, {16{32'h3F800000}});
        request(3'd0, 32'h0000_0001, 7'd64);
        check("R11", out_vec, ramp);
        check("R2", {511'd0, out_valid}, 512'd1);
        @(negedge clk);
        check("R2", {511'd0, out_valid}, '0);

        // R2: result held across idle cycles.
        held = out_vec;
        repeat (3) @(negedge clk);
        check("R2", out_vec, held);

        // R4: byte cut-off at colsb=6.
        request(3'd0, 32'h0000_0001, 7'd6);
        exp = '0;
        exp[47:0] = ramp[47:0];
        check("R4", out_vec, exp);

        // R5: lane cut-off at colsb=6 keeps only lane 0.
        request(3'd2, 32'h0000_0002, 7'd6);
        check("R5", out_vec, {480'd0, 32'h3F800000});

        // R5: colsb=0 zeroes every lane.
        request(3'd4, 32'h0000_0002, 7'd0);
        check("R5", out_vec, '0);

        // R3: chunk 1 lies past a 64-byte row.
        request(3'd0, 32'h0001_0001, 7'd64);
        check("R3", out_vec, '0);
        request(3'd2, 32'h0001_0002, 7'd64);
        check("R3", out_vec, '0);

        // R3: row index 16 gives zeros even with data in all rows.
        request(3'd0, 32'h0000_0010, 7'd64);
        check("R3", out_vec, '0);

        // R3: row 2 distinct from row 1.
        request(3'd0, 32'h0000_0002, 7'd64);
        check("R3", out_vec, {16{32'h3F800000}});

        // R10: unused code right after a nonzero result.
        request(3'd6, 32'h0000_0001, 7'd64);
        check("R10", out_vec, '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule